// File: doc/BRIEF.md
# Consecutive-Read Run Monitor

This block watches the event stream of a cache. Each event names one line of the cache and says what happened to it: the line was filled after a miss, read on a hit, written on a hit, or evicted. For each line the block measures the unbroken stretches of reads that fall between writes. A stretch is called a run. When a write, an eviction or a refill ends a run, the block adds the run's length to a global sum and adds one to a global count. Software divides the sum by the count to get the mean number of reads per run.

The block differs from a reuse counter because writes are not accesses here. A write only ends a run. A residency with runs of 3, 1 and 2 reads gives a mean of 2, whatever the number of writes between those runs. Each line keeps a resident flag and an 8-bit saturating run counter. The two global accumulators saturate instead of wrapping. A small register port reads both accumulators and clears them.

Top module: `crun_monitor`

## Requirements
- R1: After reset both accumulators read 0. Register address 0 returns the run-length sum and address 1 returns the run count, both zero-extended to 32 bits. Addresses 2 and 3 read 0.
- R2: An event is taken only when `ev_valid` is high. The kind codes are 0 = fill, 1 = read, 2 = write, 3 = evict. A read to a resident line adds one to that line's run. A read to a non-resident line has no effect.
- R3: A write to a resident line whose run is non-zero adds the run length to the sum and adds 1 to the count. Both changes can be read back in the cycle after the event. The line's run then restarts from zero.
- R4: A run of zero reads is not counted. This covers a write that follows a write, and a write or eviction that comes right after a fill. Such events leave both accumulators unchanged.
- R5: An eviction closes the open run in the same way as a write. The line then stops being resident, so later reads to it are ignored.
- R6: A fill to a line that is already resident first closes that line's open run. It then starts a new residency with a run of zero.
- R7: A line's run counter saturates at 255. A run longer than 255 reads adds 255 when it closes.
- R8: The sum saturates at 2^ACC_W-1, and so does the count. ACC_W defaults to 32.
- R9: A register write to address 2 with bit 0 set clears both accumulators. If a run closes in the same cycle, the clear wins. A write to address 2 with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 2 | Event kind: 0 fill, 1 read, 2 write, 3 evict |
| ev_line | input | LINE_W | Cache line index of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data; bit 0 of address 2 is the clear |
| reg_rdata | output | 32 | Register read data, combinational from address |

## Verification
The bench checks that runs of zero reads are dropped. It uses back-to-back writes, a write right after a fill and an eviction right after a fill. A design that counted these runs would show a count that is too high while the sum stays flat. It exercises a refill of a resident line, disabled events and reads to evicted lines. Getting any of these wrong would add runs that should not exist or lose runs that should. The bench drives the per-line counter past 255, and the sum and count to their limits on a narrowed accumulator, to catch wrap-around. It also issues a clear in the same cycle as a closing write, which exposes a design where the update wins over the clear.

// File: rtl/crun_pkg.sv
package crun_pkg;

    localparam int RUN_W  = 8;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        EV_FILL  = 2'd0,
        EV_READ  = 2'd1,
        EV_WRITE = 2'd2,
        EV_EVICT = 2'd3
    } ev_kind_e;

    localparam logic [1:0] ADDR_SUM   = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    typedef struct packed {
        logic             resident;
        logic [RUN_W-1:0] run;
    } line_st_t;

    typedef struct packed {
        logic             fire;
        logic [RUN_W-1:0] len;
    } close_t;

    function automatic logic [RUN_W-1:0] run_sat_inc(input logic [RUN_W-1:0] r);
        return (&r) ? r : r + RUN_W'(1);
    endfunction

    function automatic line_st_t line_next(input line_st_t cur, input ev_kind_e kind);
        line_st_t nx;
        nx = cur;
        case (kind)
            EV_FILL:  begin nx.resident = 1'b1; nx.run = '0; end
            EV_READ:  if (cur.resident) nx.run = run_sat_inc(cur.run);
            EV_WRITE: if (cur.resident) nx.run = '0;
            EV_EVICT: begin nx.resident = 1'b0; nx.run = '0; end
            default:  nx = cur;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/crun_line_table.sv
module crun_line_table
    import crun_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  ev_kind_e          ev_kind,
    input  logic [LINE_W-1:0] ev_line,
    output close_t            close_o
);

    line_st_t st_all [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        line_st_t st_r;
        logic     hit;
        assign hit = ev_valid && (ev_line == LINE_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                st_r <= '0;
            end else if (hit) begin
                st_r <= line_next(st_r, ev_kind);
            end
        end
        assign st_all[g] = st_r;
    end

    line_st_t cur;
    always_comb begin
        cur          = st_all[ev_line];
        close_o.len  = cur.run;
        close_o.fire = ev_valid && cur.resident && (cur.run != '0)
                       && (ev_kind != EV_READ);
    end

endmodule

// File: rtl/crun_accum.sv
module crun_accum
    import crun_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  close_t           close_i,
    output logic [ACC_W-1:0] sum_o,
    output logic [ACC_W-1:0] count_o
);

    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W:0]   sum_wide;
    logic [ACC_W-1:0] sum_d;
    logic [ACC_W-1:0] count_d;

    always_comb begin
        sum_wide = {1'b0, sum_o} + (ACC_W+1)'(close_i.len);
        sum_d    = sum_wide[ACC_W] ? ACC_MAX : sum_wide[ACC_W-1:0];
        count_d  = (count_o == ACC_MAX) ? ACC_MAX : count_o + ACC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_o   <= '0;
            count_o <= '0;
        end else if (close_i.fire) begin
            sum_o   <= sum_d;
            count_o <= count_d;
        end
    end

endmodule

// File: rtl/crun_regs.sv
module crun_regs
    import crun_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ACC_W-1:0]  sum_i,
    input  logic [ACC_W-1:0]  count_i,
    output logic              clr_o,
    output logic [DATA_W-1:0] reg_rdata
);

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[DATA_W-1:1];

    assign clr_o = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0];

    always_comb begin
        case (reg_addr)
            ADDR_SUM:   reg_rdata = DATA_W'(sum_i);
            ADDR_COUNT: reg_rdata = DATA_W'(count_i);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crun_monitor.sv
module crun_monitor
    import crun_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int LINE_W = $clog2(NLINES),
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [LINE_W-1:0] ev_line,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    close_t           close_w;
    logic             clr_w;
    logic [ACC_W-1:0] sum_w;
    logic [ACC_W-1:0] count_w;

    crun_line_table #(.NLINES(NLINES), .LINE_W(LINE_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind_e'(ev_kind)),
        .ev_line  (ev_line),
        .close_o  (close_w)
    );

    crun_accum #(.ACC_W(ACC_W)) accum_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_w),
        .close_i (close_w),
        .sum_o   (sum_w),
        .count_o (count_w)
    );

    crun_regs #(.ACC_W(ACC_W)) regs_i (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sum_i     (sum_w),
        .count_i   (count_w),
        .clr_o     (clr_w),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/crun_monitor_chk.sv
module crun_monitor_chk
    import crun_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input close_t           close_ev,
    input logic [ACC_W-1:0] sum,
    input logic [ACC_W-1:0] count
);

    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum == '0 && count == '0)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !close_ev.fire) |=> ($stable(sum) && $stable(count))); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && close_ev.fire && count != ACC_MAX) |=> count == $past(count) + ACC_W'(1)); // R3

    AST_COUNT_PINNED: assert property (@(posedge clk) disable iff (rst)
        (!clr && count == ACC_MAX) |=> count == ACC_MAX); // R8

    AST_SUM_GROWS: assert property (@(posedge clk) disable iff (rst)
        (!clr && close_ev.fire) |=> (sum > $past(sum) || sum == ACC_MAX)); // R3

endmodule

bind crun_monitor crun_monitor_chk #(.ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_w),
    .close_ev (close_w),
    .sum      (sum_w),
    .count    (count_w)
);

// File: tb/crun_monitor_tb_top.sv
module crun_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 8;
    localparam int LW         = 3;
    localparam int AW         = 10;
    localparam longint AMAX   = (longint'(1) << AW) - 1;
    localparam int K_FILL = 0, K_READ = 1, K_WRITE = 2, K_EVICT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_valid = 1'b0;
    logic [1:0]    ev_kind = '0;
    logic [LW-1:0] ev_line = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    crun_monitor #(.NLINES(NL), .LINE_W(LW), .ACC_W(AW)) dut_i (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_line(ev_line), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    int     cyc    = 0;
    int     ref_res [NL];
    int     ref_run [NL];
    longint ref_sum = 0;
    longint ref_cnt = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        reg_addr = 2'd0; #1;
        check({tag, " sum"}, longint'(reg_rdata), ref_sum);
        reg_addr = 2'd1; #1;
        check({tag, " count"}, longint'(reg_rdata), ref_cnt);
    endtask

    task automatic ref_close(input int l);
        if (ref_res[l] != 0 && ref_run[l] > 0) begin
            ref_sum = (ref_sum + ref_run[l] > AMAX) ? AMAX : ref_sum + ref_run[l];
            ref_cnt = (ref_cnt + 1 > AMAX) ? AMAX : ref_cnt + 1;
        end
    endtask

    // compare the state left by the previous event, then drive one cycle
    task automatic step(input string tag, input bit v, input int kind, input int l,
                        input bit wr, input int wd);
        @(negedge clk);
        compare(tag);
        ev_valid  = v;
        ev_kind   = 2'(kind);
        ev_line   = LW'(l);
        reg_wr    = wr;
        reg_addr  = 2'd2;
        reg_wdata = 32'(wd);
        if (v) begin
            case (kind)
                K_FILL:  begin ref_close(l); ref_res[l] = 1; ref_run[l] = 0; end
                K_READ:  if (ref_res[l] != 0 && ref_run[l] < 255) ref_run[l]++;
                K_WRITE: begin ref_close(l); ref_run[l] = 0; end
                default: begin ref_close(l); ref_res[l] = 0; ref_run[l] = 0; end
            endcase
        end
        if (wr && wd[0]) begin
            ref_sum = 0;
            ref_cnt = 0;
        end
    endtask

    task automatic ev(input string tag, input int kind, input int l);
        step(tag, 1'b1, kind, l, 1'b0, 0);
    endtask

    task automatic reads(input string tag, input int l, input int n);
        for (int i = 0; i < n; i++) ev(tag, K_READ, l);
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin ref_res[i] = 0; ref_run[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state and unused addresses
        compare("R1");
        reg_addr = 2'd2; #1; check("R1 addr2", longint'(reg_rdata), 0);
        reg_addr = 2'd3; #1; check("R1 addr3", longint'(reg_rdata), 0);

        // R2 R3 R5: runs 2,1,3 on one residency
        ev("R2", K_FILL, 1);
        reads("R2", 1, 2);
        ev("R3", K_WRITE, 1);
        reads("R2", 1, 1);
        ev("R3", K_WRITE, 1);
        reads("R2", 1, 3);
        ev("R5", K_EVICT, 1);
        reads("R5", 1, 2);           // evicted line: ignored
        ev("R5", K_WRITE, 1);

        // R2: read to a non-resident line, then fill and write
        ev("R2", K_READ, 2);
        ev("R2", K_FILL, 2);
        ev("R4", K_WRITE, 2);

        // R4: zero-length runs
        ev("R4", K_FILL, 3);
        ev("R4", K_WRITE, 3);
        ev("R4", K_WRITE, 3);
        ev("R4", K_EVICT, 3);
        ev("R4", K_FILL, 3);
        ev("R4", K_EVICT, 3);

        // R6: fill on a resident line closes its run
        ev("R6", K_FILL, 4);
        reads("R6", 4, 1);
        ev("R6", K_FILL, 4);
        ev("R6", K_WRITE, 4);

        // R2: disabled event has no effect
        ev("R2", K_FILL, 5);
        reads("R2", 5, 1);
        step("R2", 1'b0, K_WRITE, 5, 1'b0, 0);
        reads("R2", 5, 1);
        ev("R2", K_WRITE, 5);

        // interleaved lines
        ev("R3", K_FILL, 0);
        ev("R3", K_FILL, 6);
        for (int i = 0; i < 4; i++) begin ev("R3", K_READ, 0); ev("R3", K_READ, 6); end
        reads("R3", 0, 1);
        ev("R3", K_WRITE, 0);
        ev("R5", K_EVICT, 6);

        // R7: per-line saturation
        ev("R7", K_FILL, 6);
        reads("R7", 6, 300);
        ev("R7", K_WRITE, 6);

        // R9: clear variants
        step("R9", 1'b0, K_READ, 0, 1'b1, 32'h2);   // bit0 clear: no effect
        step("R9", 1'b0, K_READ, 0, 1'b1, 1);
        step("R9", 1'b0, K_READ, 0, 1'b0, 0);
        reads("R9", 0, 2);
        step("R9", 1'b1, K_WRITE, 0, 1'b1, 1);      // clear beats close
        reads("R9", 0, 1);
        ev("R9", K_WRITE, 0);

        // R8: sum saturation
        step("R8", 1'b0, K_READ, 0, 1'b1, 1);
        ev("R8", K_FILL, 7);
        for (int k = 0; k < 5; k++) begin
            reads("R8", 7, 256);
            ev("R8", K_WRITE, 7);
        end
        // R8: count saturation
        step("R8", 1'b0, K_READ, 0, 1'b1, 1);
        for (int k = 0; k < 1030; k++) begin
            ev("R8", K_READ, 7);
            ev("R8", K_WRITE, 7);
        end

        step("R8", 1'b0, K_READ, 0, 1'b0, 0);
        @(negedge clk);
        compare("R8");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule